// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage integer pipeline. It takes the two source register numbers of the instruction now in execute. It compares them with the destination register numbers of the two older instructions still in flight: the one in the memory stage and the one in write-back. For each ALU operand it produces a 2-bit select and the selected operand. The operand is either the value read from the register file, the ALU result of the instruction just ahead, or the value about to be written back.

The logic is purely combinational. A forward is only taken from a stage that will really write its destination, and never when that destination is the hard-wired zero register (number 31). When both older stages match the same source, the younger result from the memory stage wins, so a chain of instructions that all update one register reads the newest value. No forward is needed from beyond write-back, because the register file returns the value being written when the same register is read in the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: An operand's select is 2'b10 and its output equals the memory-stage result when the memory-stage write enable is 1, the memory-stage destination is not 31, and it equals that operand's source number.
- R2: An operand's select is 2'b01 and its output equals the write-back value when the write-back enable is 1, the write-back destination is not 31, it equals that operand's source number, and the R1 condition is false for that operand.
- R3: When the R1 and R2 conditions both hold for an operand, the select is 2'b10 and the memory-stage result is passed.
- R4: A destination number of 31 in either stage never causes a forward, even with its write enable at 1 and a matching source.
- R5: A stage whose write enable is 0 never causes a forward, even when its destination matches.
- R6: With no forwarding condition true, the select is 2'b00 and the output equals that operand's register-file value.
- R7: Operand A (compared against src_a) and operand B (compared against src_b) are resolved independently, so each can take a different source in the same cycle.
- R8: The select value 2'b11 never appears on either select output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| exm_rd | input | 5 | Destination register number held in the memory stage |
| exm_wen | input | 1 | Memory-stage instruction writes its destination |
| mwb_rd | input | 5 | Destination register number held in the write-back stage |
| mwb_wen | input | 1 | Write-back-stage instruction writes its destination |
| rf_a | input | 64 | Register-file value for operand A |
| rf_b | input | 64 | Register-file value for operand B |
| exm_result | input | 64 | ALU result held in the memory stage |
| mwb_value | input | 64 | Value being written back (load data or older ALU result) |
| sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | 64 | Resolved ALU operand A |
| opnd_b | output | 64 | Resolved ALU operand B |

## Verification
The bench drives a chain where both older stages write the source register. A unit with the wrong priority would hand the ALU the stale write-back value. It matches a destination of 31 in both stages, where a unit missing the exclusion would forward a result that should read as zero. It presents matching destinations whose write enables are low, which a unit that ignores the enable would forward from a store or branch. It sets the two operands to different sources in one cycle to catch select logic that is shared or swapped between operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     hit_exm;
        logic     hit_wb;
        fwd_sel_e sel;
    } lane_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W    = 5,
    parameter int ZERO_REG = 31
) (
    input  logic             wen,
    input  logic [REG_W-1:0] rd,
    input  logic [REG_W-1:0] src,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_NUM = REG_W'(ZERO_REG);

    always_comb begin
        hit = wen && (rd != ZERO_NUM) && (rd == src);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     hit_exm,
    input  logic     hit_wb,
    output fwd_sel_e sel
);
    always_comb begin
        if (hit_exm) begin
            sel = SEL_EXM;
        end else if (hit_wb) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_RF;
        end
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        case (sel)
            SEL_EXM: out = exm_val;
            SEL_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int DATA_W   = 64,
    parameter int ZERO_REG = 31
) (
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [REG_W-1:0]  exm_rd,
    input  logic              exm_wen,
    input  logic [REG_W-1:0]  mwb_rd,
    input  logic              mwb_wen,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [DATA_W-1:0] mwb_value,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int LANES = 2;

    logic [REG_W-1:0]  src_d [LANES];
    logic [DATA_W-1:0] rf_d  [LANES];
    logic [DATA_W-1:0] out_d [LANES];
    lane_t             lane_d [LANES];

    always_comb begin
        src_d[0] = src_a;
        src_d[1] = src_b;
        rf_d[0]  = rf_a;
        rf_d[1]  = rf_b;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fwd_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_m_exm (
            .wen (exm_wen),
            .rd  (exm_rd),
            .src (src_d[g]),
            .hit (lane_d[g].hit_exm)
        );
        fwd_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_m_wb (
            .wen (mwb_wen),
            .rd  (mwb_rd),
            .src (src_d[g]),
            .hit (lane_d[g].hit_wb)
        );
        fwd_pick u_pick (
            .hit_exm (lane_d[g].hit_exm),
            .hit_wb  (lane_d[g].hit_wb),
            .sel     (lane_d[g].sel)
        );
        fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (lane_d[g].sel),
            .rf_val  (rf_d[g]),
            .exm_val (exm_result),
            .wb_val  (mwb_value),
            .out     (out_d[g])
        );
    end

    always_comb begin
        sel_a  = lane_d[0].sel;
        sel_b  = lane_d[1].sel;
        opnd_a = out_d[0];
        opnd_b = out_d[1];
    end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W    = 5,
    parameter int DATA_W   = 64,
    parameter int ZERO_REG = 31
) (
    input logic [REG_W-1:0]  src_a,
    input logic [REG_W-1:0]  src_b,
    input logic [REG_W-1:0]  exm_rd,
    input logic              exm_wen,
    input logic [REG_W-1:0]  mwb_rd,
    input logic              mwb_wen,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] exm_result,
    input logic [DATA_W-1:0] mwb_value,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a
);
    localparam logic [REG_W-1:0] ZNUM = REG_W'(ZERO_REG);

    logic known;
    logic ex_ok_a;
    logic wb_ok_a;

    always_comb begin
        known   = !$isunknown({src_a, src_b, exm_rd, exm_wen, mwb_rd, mwb_wen, sel_a, sel_b});
        ex_ok_a = exm_wen && exm_rd != ZNUM && exm_rd == src_a;
        wb_ok_a = mwb_wen && mwb_rd != ZNUM && mwb_rd == src_a;
        if (known) begin
            AST_EXM_NEEDS_MATCH: assert (sel_a != 2'b10 || ex_ok_a); // R1
            AST_WB_NEEDS_MATCH:  assert (sel_a != 2'b01 || (wb_ok_a && !ex_ok_a)); // R2
            AST_EXM_WINS:        assert (!ex_ok_a || sel_a == 2'b10); // R3
            AST_ZERO_NO_FWD:     assert (!(exm_rd == ZNUM && mwb_rd == ZNUM) || sel_a == 2'b00); // R4
            AST_WEN_LOW_NO_FWD:  assert ((exm_wen || mwb_wen) || (sel_a == 2'b00 && sel_b == 2'b00)); // R5
            AST_NO_SEL_11:       assert (sel_a != 2'b11 && sel_b != 2'b11); // R8
            if (!$isunknown({rf_a, exm_result, mwb_value})) begin
                AST_DATA_EXM: assert (sel_a != 2'b10 || opnd_a == exm_result); // R1
                AST_DATA_RF:  assert (sel_a != 2'b00 || opnd_a == rf_a); // R6
            end
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W), .ZERO_REG(ZERO_REG)) u_chk (
    .src_a      (src_a),
    .src_b      (src_b),
    .exm_rd     (exm_rd),
    .exm_wen    (exm_wen),
    .mwb_rd     (mwb_rd),
    .mwb_wen    (mwb_wen),
    .rf_a       (rf_a),
    .exm_result (exm_result),
    .mwb_value  (mwb_value),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .opnd_a     (opnd_a)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic [RW-1:0] src_a = '0, src_b = '0, exm_rd = '0, mwb_rd = '0;
    logic          exm_wen = 1'b0, mwb_wen = 1'b0;
    logic [DW-1:0] rf_a = 64'hAAAA_0000_0000_0001;
    logic [DW-1:0] rf_b = 64'hBBBB_0000_0000_0002;
    logic [DW-1:0] exm_result = 64'hEEEE_0000_0000_0003;
    logic [DW-1:0] mwb_value  = 64'h5555_0000_0000_0004;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_unit #(.REG_W(RW), .DATA_W(DW), .ZERO_REG(31)) u_dut (
        .src_a(src_a), .src_b(src_b), .exm_rd(exm_rd), .exm_wen(exm_wen),
        .mwb_rd(mwb_rd), .mwb_wen(mwb_wen), .rf_a(rf_a), .rf_b(rf_b),
        .exm_result(exm_result), .mwb_value(mwb_value),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(logic [RW-1:0] a, logic [RW-1:0] b,
                         logic [RW-1:0] xr, logic xw, logic [RW-1:0] wr, logic ww);
        @(negedge clk);
        src_a = a; src_b = b; exm_rd = xr; exm_wen = xw; mwb_rd = wr; mwb_wen = ww;
        #1;
    endtask

    task automatic t_idle();
        drive(5'd3, 5'd4, 5'd7, 1'b0, 5'd8, 1'b0);
        chk("R6 sel_a", 64'(sel_a), 64'(2'b00));
        chk("R6 sel_b", 64'(sel_b), 64'(2'b00));
        chk("R6 opnd_a", opnd_a, rf_a);
        chk("R6 opnd_b", opnd_b, rf_b);
    endtask

    task automatic t_ex_hit();
        drive(5'd2, 5'd5, 5'd2, 1'b1, 5'd9, 1'b1);
        chk("R1 sel_a", 64'(sel_a), 64'(2'b10));
        chk("R1 opnd_a", opnd_a, exm_result);
        chk("R7 sel_b", 64'(sel_b), 64'(2'b00));
        chk("R7 opnd_b", opnd_b, rf_b);
    endtask

    task automatic t_wb_hit();
        drive(5'd6, 5'd2, 5'd12, 1'b1, 5'd2, 1'b1);
        chk("R2 sel_b", 64'(sel_b), 64'(2'b01));
        chk("R2 opnd_b", opnd_b, mwb_value);
        chk("R7 sel_a", 64'(sel_a), 64'(2'b00));
    endtask

    task automatic t_double();
        drive(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1);
        chk("R3 sel_a", 64'(sel_a), 64'(2'b10));
        chk("R3 sel_b", 64'(sel_b), 64'(2'b10));
        chk("R3 opnd_a", opnd_a, exm_result);
        chk("R3 opnd_b", opnd_b, exm_result);
    endtask

    task automatic t_zero();
        drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1);
        chk("R4 sel_a", 64'(sel_a), 64'(2'b00));
        chk("R4 sel_b", 64'(sel_b), 64'(2'b00));
        chk("R4 opnd_a", opnd_a, rf_a);
        drive(5'd31, 5'd0, 5'd31, 1'b1, 5'd0, 1'b1);
        chk("R4 exm zero sel_a", 64'(sel_a), 64'(2'b00));
        chk("R4 wb reg0 sel_b", 64'(sel_b), 64'(2'b01));
    endtask

    task automatic t_wen_low();
        drive(5'd4, 5'd4, 5'd4, 1'b0, 5'd4, 1'b0);
        chk("R5 sel_a", 64'(sel_a), 64'(2'b00));
        chk("R5 opnd_b", opnd_b, rf_b);
        drive(5'd4, 5'd9, 5'd4, 1'b0, 5'd4, 1'b1);
        chk("R5 exm off wb on sel_a", 64'(sel_a), 64'(2'b01));
        chk("R5 exm off wb on opnd_a", opnd_a, mwb_value);
    endtask

    task automatic t_split();
        drive(5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1);
        chk("R7 split sel_a", 64'(sel_a), 64'(2'b10));
        chk("R7 split sel_b", 64'(sel_b), 64'(2'b01));
        chk("R7 split opnd_b", opnd_b, mwb_value);
        drive(5'd11, 5'd10, 5'd10, 1'b1, 5'd11, 1'b1);
        chk("R7 swap sel_a", 64'(sel_a), 64'(2'b01));
        chk("R7 swap sel_b", 64'(sel_b), 64'(2'b10));
        chk("R8 sel_a not 11", 64'(sel_a == 2'b11), 64'(0));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_idle();
        t_ex_hit();
        t_wb_hit();
        t_double();
        t_zero();
        t_wen_low();
        t_split();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (1000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule